// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a 4,608-bit embedded memory with one write port and one read port, each on its own clock. Each port is given its own data width at reset, chosen from 1, 2, 4, 9 and 18 bits. Because the widths are independent, data stored through a narrow port can be fetched as one wide word, and a wide word can be fetched back piece by piece, for example as a serial stream of single bits.

Storage is 256 rows of 18 bits. A port narrower than 18 bits sees each row as a set of equal lanes. The low address bits pick the lane and the upper bits pick the row. The 9- and 18-bit widths share the full 18-bit row. The 1-, 2- and 4-bit widths share the low 16 bits of each row, which gives 4,096 usable bits. A read is synchronous: the selected lane lands in an output register on the read clock edge. This register keeps its value on cycles with no read.

Top module: `mixed_width_ram`

## Requirements
- R1: The width codes on `wrWidth` and `rdWidth` are 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 9 bits and 4 = 18 bits. They are captured on each clock edge while `rstN` is low and are then held. A change on these inputs after reset has no effect.
- R2: Only these width pairings are legal: both widths from {9, 18}, or both widths from {1, 2, 4}.
- R3: A port of width w has L lanes per row (18→1, 9→2, 4→4, 2→8, 1→16). The row is (addr / L) mod 256 and the lane is addr mod L. Lane k occupies row bits [k*w +: w], with lane 0 at the least significant end. Address bits above the ones needed are ignored.
- R4: A write with `wrEn` high on a `wrClk` edge updates only the addressed lane. The other bits of the row keep their values. Bits of `wrData` above the port width are ignored.
- R5: A read with `rdEn` high on a `rdClk` edge places the addressed lane in `rdData[w-1:0]` after that edge. The bits of `rdData` above w are 0.
- R6: While `rdEn` is low, `rdData` holds its value, even if the location it came from is written.
- R7: If the same location is read and written on the same edge, the read returns the data stored before that write.
- R8: Data written at one width reads back bit-exact at every other legal width under the R3 mapping. For example, a 4-bit value at address a reads as 1-bit values at addresses 4a to 4a+3, least significant bit first.
- R9: While `rstN` is low, `rdData` is cleared to 0 and writes are blocked. The stored contents are not reset.
- R10: A write and a read to different locations on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock |
| rdClk | input | 1 | Read port clock |
| rstN | input | 1 | Active-low synchronous reset; width codes are captured while low |
| wrWidth | input | 3 | Write port width code |
| rdWidth | input | 3 | Read port width code |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 12 | Write address in units of the write width |
| wrData | input | 18 | Write data, low w bits used |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 12 | Read address in units of the read width |
| rdData | output | 18 | Registered read data, zero above the read width |

## Verification
All thirteen legal write/read width pairings are tried. In each one, four rows are filled at the write width, a few lanes are then overwritten, and every lane of the rows is read back at the read width. A lane index or bit-order mistake shows up as a mismatch against a bit-level model, and the overwrites show whether neighbouring lanes survive a partial write. Directed patterns cover four further cases: a read collides with a write to the same or a different location, a write lands while reads are idle, addresses carry junk high bits, and the width inputs change after reset. These tell apart old-versus-new read data, a held versus a refreshed output, and a frozen versus a live width setting. A 4-bit-in, 1-bit-out case uses literal expected bits, so that the serial order is checked without relying on the model.

// File: rtl/mwram_pkg.sv
`timescale 1ns/1ps
package mwram_pkg;

  localparam int MW_DW    = 18;
  localparam int MW_WORDS = 256;
  localparam int MW_WAW   = $clog2(MW_WORDS);
  localparam int MW_AW    = MW_WAW + 4;
  localparam int MW_OFFW  = $clog2(MW_DW);

  typedef enum logic [2:0] {
    WID1  = 3'd0,
    WID2  = 3'd1,
    WID4  = 3'd2,
    WID9  = 3'd3,
    WID18 = 3'd4
  } width_e;

  // strobes from control to datapath, one set per port
  typedef struct packed {
    logic                en;
    logic [MW_WAW-1:0]   word;
    logic [MW_OFFW-1:0]  offset;
    width_e              width;
  } portStb_t;

  function automatic logic [MW_DW-1:0] laneMask(width_e w);
    case (w)
      WID1:    laneMask = MW_DW'(18'h00001);
      WID2:    laneMask = MW_DW'(18'h00003);
      WID4:    laneMask = MW_DW'(18'h0000F);
      WID9:    laneMask = MW_DW'(18'h001FF);
      default: laneMask = MW_DW'(18'h3FFFF);
    endcase
  endfunction

  function automatic int laneBits(width_e w);
    case (w)
      WID1:    laneBits = 1;
      WID2:    laneBits = 2;
      WID4:    laneBits = 4;
      WID9:    laneBits = 9;
      default: laneBits = 18;
    endcase
  endfunction

  function automatic logic pairLegal(width_e a, width_e b);
    logic aWide, bWide, aNarrow, bNarrow;
    aWide   = (a == WID9) || (a == WID18);
    bWide   = (b == WID9) || (b == WID18);
    aNarrow = (a == WID1) || (a == WID2) || (a == WID4);
    bNarrow = (b == WID1) || (b == WID2) || (b == WID4);
    pairLegal = (aWide && bWide) || (aNarrow && bNarrow);
  endfunction

endpackage

// File: rtl/mwram_decode.sv
`timescale 1ns/1ps
module mwram_decode
  import mwram_pkg::*;
#(
  parameter int WAW = MW_WAW,
  localparam int AW = WAW + 4
) (
  input  width_e               width,
  input  logic [AW-1:0]        addr,
  output logic [WAW-1:0]       word,
  output logic [MW_OFFW-1:0]   offset
);

  // low address bits choose the lane, the rest choose the row
  always_comb begin
    case (width)
      WID18: begin
        word   = addr[WAW-1:0];
        offset = '0;
      end
      WID9: begin
        word   = addr[WAW:1];
        offset = addr[0] ? MW_OFFW'(9) : '0;
      end
      WID4: begin
        word   = addr[WAW+1:2];
        offset = {1'b0, addr[1:0], 2'b00};
      end
      WID2: begin
        word   = addr[WAW+2:3];
        offset = {1'b0, addr[2:0], 1'b0};
      end
      default: begin
        word   = addr[WAW+3:4];
        offset = {1'b0, addr[3:0]};
      end
    endcase
  end

endmodule

// File: rtl/mwram_ctrl.sv
`timescale 1ns/1ps
module mwram_ctrl
  import mwram_pkg::*;
#(
  parameter int WAW = MW_WAW,
  localparam int AW = WAW + 4
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic [2:0]    wrWidthIn,
  input  logic [2:0]    rdWidthIn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output portStb_t      wrStb,
  output portStb_t      rdStb
);

  width_e wrCfg;
  width_e rdCfg;

  // width settings are sampled only while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) wrCfg <= width_e'(wrWidthIn);
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) rdCfg <= width_e'(rdWidthIn);
  end

  logic [WAW-1:0]     wrWord, rdWord;
  logic [MW_OFFW-1:0] wrOff, rdOff;

  mwram_decode #(.WAW(WAW)) uWrDec (
    .width(wrCfg), .addr(wrAddr), .word(wrWord), .offset(wrOff)
  );

  mwram_decode #(.WAW(WAW)) uRdDec (
    .width(rdCfg), .addr(rdAddr), .word(rdWord), .offset(rdOff)
  );

  always_comb begin
    wrStb.en     = wrEn && rstN;
    wrStb.word   = wrWord;
    wrStb.offset = wrOff;
    wrStb.width  = wrCfg;
    rdStb.en     = rdEn && rstN;
    rdStb.word   = rdWord;
    rdStb.offset = rdOff;
    rdStb.width  = rdCfg;
  end

  // R2: the two captured widths must form a legal pairing
  a_r2_legal_pair: assert property (@(posedge rdClk) disable iff (!rstN)
    pairLegal(wrCfg, rdCfg));

endmodule

// File: rtl/mwram_dp.sv
`timescale 1ns/1ps
module mwram_dp
  import mwram_pkg::*;
#(
  parameter int DW    = MW_DW,
  parameter int WORDS = MW_WORDS
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  portStb_t      wrStb,
  input  logic [DW-1:0] wrData,
  input  portStb_t      rdStb,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] wrMask;
  logic [DW-1:0] wrShift;

  assign wrMask  = laneMask(wrStb.width) << wrStb.offset;
  assign wrShift = (wrData & laneMask(wrStb.width)) << wrStb.offset;

  // per-bit lane write keeps neighbouring lanes untouched
  always_ff @(posedge wrClk) begin
    if (wrStb.en) begin
      for (int b = 0; b < DW; b++) begin
        if (wrMask[b]) mem[wrStb.word][b] <= wrShift[b];
      end
    end
  end

  // registered read; nonblocking update yields pre-write data on collision
  always_ff @(posedge rdClk) begin
    if (!rstN)          rdData <= '0;
    else if (rdStb.en)  rdData <= (mem[rdStb.word] >> rdStb.offset) & laneMask(rdStb.width);
  end

  // R4: a write touches exactly one lane's worth of bits
  a_r4_mask_width: assert property (@(posedge wrClk) disable iff (!rstN)
    wrStb.en |-> $countones(wrMask) == laneBits(wrStb.width));

  // R3: the addressed lane lies fully inside the row
  a_r3_lane_in_row: assert property (@(posedge wrClk) disable iff (!rstN)
    wrStb.en |-> (int'(wrStb.offset) + laneBits(wrStb.width)) <= DW);

  // R6: no read, no change on the output
  a_r6_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdStb.en |=> $stable(rdData));

  // R5: bits above the read width stay zero
  a_r5_upper_zero: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdData & ~laneMask(rdStb.width)) == '0);

endmodule

// File: rtl/mixed_width_ram.sv
`timescale 1ns/1ps
module mixed_width_ram
  import mwram_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [2:0]        wrWidth,
  input  logic [2:0]        rdWidth,
  input  logic              wrEn,
  input  logic [MW_AW-1:0]  wrAddr,
  input  logic [MW_DW-1:0]  wrData,
  input  logic              rdEn,
  input  logic [MW_AW-1:0]  rdAddr,
  output logic [MW_DW-1:0]  rdData
);

  portStb_t wrStb;
  portStb_t rdStb;

  mwram_ctrl #(.WAW(MW_WAW)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrWidthIn(wrWidth), .rdWidthIn(rdWidth),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  mwram_dp #(.DW(MW_DW), .WORDS(MW_WORDS)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb), .rdData(rdData)
  );

endmodule

// File: tb/sim_mixed_width_ram.sv
`timescale 1ns/1ps
module sim_mixed_width_ram;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  wrWidth, rdWidth;
  logic        wrEn, rdEn;
  logic [11:0] wrAddr, rdAddr;
  logic [17:0] wrData;
  logic [17:0] rdData;

  always #2 clk = ~clk;

  mixed_width_ram u0 (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrWidth(wrWidth), .rdWidth(rdWidth),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nRun  = 0;
  int nFail = 0;
  bit done  = 0;
  bit refMem [0:4607];

  function automatic int wBits(int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 9;
      default: return 18;
    endcase
  endfunction

  function automatic int lanesOf(int c);
    case (c)
      0: return 16;
      1: return 8;
      2: return 4;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int bitBase(int c, int addr);
    int L = lanesOf(c);
    return ((addr / L) % 256) * 18 + (addr % L) * wBits(c);
  endfunction

  function automatic logic [17:0] refRead(int c, int addr);
    logic [17:0] r = '0;
    int base = bitBase(c, addr);
    for (int i = 0; i < wBits(c); i++) r[i] = refMem[base + i];
    return r;
  endfunction

  task automatic refWrite(int c, int addr, logic [17:0] d);
    int base = bitBase(c, addr);
    for (int i = 0; i < wBits(c); i++) refMem[base + i] = d[i];
  endtask

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(int wc, int rc);
    @(negedge clk);
    rstN = 1'b0; wrWidth = 3'(wc); rdWidth = 3'(rc);
    wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 output cleared in reset", rdData, 18'h0);
    rstN = 1'b1;
  endtask

  task automatic doWrite(int c, int addr, logic [17:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 12'(addr); wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
    refWrite(c, addr, d);
  endtask

  task automatic doRead(int c, int addr, string req);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 12'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    check(req, rdData, refRead(c, addr));
  endtask

  // R2 R3 R4 R5 R8: every legal pairing against the bit model
  task automatic tPair(int wc, int rc);
    doReset(wc, rc);
    for (int a = 0; a < 4 * lanesOf(wc); a++) doWrite(wc, a, 18'($urandom));
    for (int k = 0; k < 6; k++) doWrite(wc, int'($urandom % (4 * lanesOf(wc))), 18'($urandom));
    for (int a = 0; a < 4 * lanesOf(rc); a++)
      doRead(rc, a, $sformatf("R3/R4/R5/R8 pair w%0d r%0d addr %0d", wBits(wc), wBits(rc), a));
  endtask

  // R8: 4-bit in, serial 1-bit out with literal expectations
  task automatic tSerial();
    doReset(2, 0);
    doWrite(2, 3, 18'h3FFFA);
    doRead(0, 12, "R8 serial bit0");
    check("R8 serial bit0 literal", rdData, 18'h0);
    doRead(0, 13, "R8 serial bit1");
    check("R8 serial bit1 literal", rdData, 18'h1);
    doRead(0, 14, "R8 serial bit2");
    check("R8 serial bit2 literal", rdData, 18'h0);
    doRead(0, 15, "R8 serial bit3");
    check("R8 serial bit3 literal", rdData, 18'h1);
  endtask

  // R6: output holds while idle, even across a write to its source
  task automatic tHold();
    doReset(4, 4);
    doWrite(4, 5, 18'h12345);
    doRead(4, 5, "R6 setup read");
    doWrite(4, 5, 18'h2ABCD);
    @(negedge clk);
    rdAddr = 12'd9;
    @(negedge clk);
    check("R6 hold while rdEn low", rdData, 18'h12345);
  endtask

  // R7 and R10: same-edge read and write
  task automatic tCollide();
    doReset(4, 4);
    doWrite(4, 7, 18'h0AAAA);
    doWrite(4, 8, 18'h15555);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 12'd7; wrData = 18'h3C3C3;
    rdEn = 1'b1; rdAddr = 12'd7;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    refWrite(4, 7, 18'h3C3C3);
    check("R7 collision returns old", rdData, 18'h0AAAA);
    doRead(4, 7, "R7 new data after collision");
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 12'd9; wrData = 18'h01234;
    rdEn = 1'b1; rdAddr = 12'd8;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    refWrite(4, 9, 18'h01234);
    check("R10 parallel read", rdData, 18'h15555);
    doRead(4, 9, "R10 parallel write landed");
  endtask

  // R3 high address bits ignored; R1 widths frozen after reset
  task automatic tAddrAndCfg();
    doReset(4, 4);
    doWrite(4, 12'hF0A, 18'h2F00D);
    doRead(4, 12'h00A, "R3 high bits ignored w18");
    @(negedge clk);
    rdWidth = 3'd0;
    doRead(4, 12'h00A, "R1 width change after reset ignored");
    check("R1 literal full width", rdData, 18'h2F00D);
    doReset(3, 3);
    doWrite(3, 12'hE03, 18'h1A5);
    doRead(3, 12'h003, "R3 high bits ignored w9");
    check("R3 literal w9", rdData, 18'h1A5);
  endtask

  initial begin
    rstN = 1'b0; wrWidth = '0; rdWidth = '0;
    wrEn = 1'b0; rdEn = 1'b0; wrAddr = '0; rdAddr = '0; wrData = '0;
    for (int w = 0; w < 3; w++)
      for (int r = 0; r < 3; r++) tPair(w, r);
    for (int w = 3; w < 5; w++)
      for (int r = 3; r < 5; r++) tPair(w, r);
    tSerial();
    tHold();
    tCollide();
    tAddrAndCfg();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule